// File: doc/BRIEF.md
# Token-Ring FIFO Slice for Depth Expansion

This block is one storage slice of a first-in/first-out buffer that grows in depth by chaining identical slices in a ring. Every slice sees the same write strobe, read strobe and write data. Two tokens travel around the ring, one for writing and one for reading. Only the slice holding the write token stores incoming words. Only the slice holding the read token returns data. A slice passes a token on by raising a one-cycle pass pulse towards the next slice. It does this in the same cycle in which it accepts the strobe for its last location, so the ring loses no cycle at a slice boundary.

The slice holding the read token puts its output word on the bus. Every other slice drives zero, so the ring's read data is the OR of all slice outputs. Each slice reports its own empty and full flags. The ring is empty only when every slice is empty, and full only when every slice is full. A strap input picks either ring mode or stand-alone mode. In stand-alone mode the slice is a plain circular FIFO that ignores tokens.

Top module: `depth_slice`

## Requirements
- R1: While rst_ni is low and after it is released, the slice reports empty_o=1, full_o=0, rd_valid_o=0, rd_data_o=0 and both pass pulses low. In ring mode, wr_own_o and rd_own_o are 1 on the slice whose first_load_ni is 0 and 0 on every other slice.
- R2: A write is accepted at a clock edge when wr_en_i=1, full_o=0 and the slice may write. It may write when it holds the write token in ring mode, and always in stand-alone mode. Accepted words are stored at consecutive locations starting from location 0.
- R3: A read is accepted at a clock edge when rd_en_i=1, empty_o=0 and the slice may read. The rule for reading is the same as for writing, using the read token. In the next cycle rd_valid_o=1 and rd_data_o holds the oldest stored word. In every other cycle rd_valid_o=0 and rd_data_o=0.
- R4: In ring mode, wr_pass_o is high during exactly the cycle whose edge accepts a write to location DEPTH-1. After that edge the slice no longer holds the write token, and its next write goes to location 0.
- R5: In ring mode, rd_pass_o is high during exactly the cycle whose edge accepts a read from location DEPTH-1. After that edge the slice no longer holds the read token, and its next read comes from location 0.
- R6: In ring mode, wr_tok_i=1 at a clock edge gives the slice the write token, and rd_tok_i=1 gives it the read token. The slice keeps a token until it passes it on.
- R7: In ring mode, a slice without the write token ignores wr_en_i, and a slice without the read token ignores rd_en_i. Its flags and read outputs stay unchanged.
- R8: With chain_en_i=0 the slice works alone as a FIFO of DEPTH words. It reports wr_own_o=rd_own_o=1, keeps both pass pulses low, ignores the token inputs and wraps its pointers past location DEPTH-1.
- R9: empty_o=1 exactly when the slice stores no word, and full_o=1 exactly when it stores DEPTH words. In a ring of N slices, the AND of all empty_o flags and the AND of all full_o flags match a single FIFO of N*DEPTH words.
- R10: A read and a write accepted at the same edge both take effect, so the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_en_i | input | 1 | 1 = ring mode, 0 = stand-alone mode |
| first_load_ni | input | 1 | 0 marks the slice that starts with both tokens |
| wr_en_i | input | 1 | Shared write strobe, one word per cycle |
| wr_data_i | input | DW | Shared write data |
| rd_en_i | input | 1 | Shared read strobe, one word per cycle |
| wr_tok_i | input | 1 | Write-token pulse from the previous slice |
| rd_tok_i | input | 1 | Read-token pulse from the previous slice |
| rd_data_o | output | DW | Read word, zero when not valid |
| rd_valid_o | output | 1 | rd_data_o holds a word read at the last edge |
| empty_o | output | 1 | Slice stores no word |
| full_o | output | 1 | Slice stores DEPTH words |
| wr_pass_o | output | 1 | Write-token pulse to the next slice |
| rd_pass_o | output | 1 | Read-token pulse to the next slice |
| wr_own_o | output | 1 | Slice currently holds the write token |
| rd_own_o | output | 1 | Slice currently holds the read token |

## Verification
The hardest condition to reach is a writer that has gone once around the ring and comes back to a slice whose old words are still unread. There, only that slice's full flag stops the write, and the tokens of the two sides sit in the same slice. A pointer error in this case would overwrite unread data. The bench drives a three-slice ring with write-heavy random bursts until the composite full flag sets, and keeps writing there. It then drains the ring with read-heavy bursts and overlapped read/write traffic across every slice boundary. A stand-alone phase first exercises a single slice's wrap without tokens.

// File: rtl/dsx_pkg.sv
package dsx_pkg;
  typedef enum logic {
    MODE_SOLO  = 1'b0,
    MODE_CHAIN = 1'b1
  } slice_mode_e;
endpackage

// File: rtl/dsx_ring_ptr.sv
module dsx_ring_ptr #(
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LastLoc = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  assign last_o = (ptr_q == LastLoc);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= last_o ? '0 : ptr_q + AW'(1);
  end
endmodule

// File: rtl/dsx_token.sv
module dsx_token (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_i,
  input  logic grant_i,
  input  logic release_i,
  output logic own_o
);
  logic own_q;

  // Reset value is the first-load strap.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= first_i;
    else         own_q <= (own_q & ~release_i) | grant_i;
  end

  assign own_o = own_q;
endmodule

// File: rtl/dsx_occ.sv
module dsx_occ #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic empty_o,
  output logic full_o
);
  localparam logic [CW-1:0] FullCnt = CW'(DEPTH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FullCnt);
endmodule

// File: rtl/dsx_store.sv
module dsx_store #(
  parameter int DW    = 9,
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // Output word is zero outside a valid cycle so slices can be OR-combined.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= re_i ? mem_q[raddr_i] : '0;
      rvalid_q <= re_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/depth_slice.sv
module depth_slice
  import dsx_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chain_en_i,
  input  logic          first_load_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          wr_tok_i,
  input  logic          rd_tok_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          wr_pass_o,
  output logic          rd_pass_o,
  output logic          wr_own_o,
  output logic          rd_own_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  slice_mode_e mode;
  assign mode = chain_en_i ? MODE_CHAIN : MODE_SOLO;

  logic          wr_tok_q, rd_tok_q;
  logic          wr_may, rd_may;
  logic          wr_acc, rd_acc;
  logic          wr_last, rd_last;
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_comb begin
    wr_may = 1'b1;
    rd_may = 1'b1;
    if (mode == MODE_CHAIN) begin
      wr_may = wr_tok_q;
      rd_may = rd_tok_q;
    end
  end

  assign wr_acc = wr_en_i & wr_may & ~full_o;
  assign rd_acc = rd_en_i & rd_may & ~empty_o;

  // Combinational pass: next slice owns the token from the same edge.
  assign wr_pass_o = (mode == MODE_CHAIN) & wr_acc & wr_last;
  assign rd_pass_o = (mode == MODE_CHAIN) & rd_acc & rd_last;
  assign wr_own_o  = wr_may;
  assign rd_own_o  = rd_may;

  dsx_token u_wr_tok (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_i  (~first_load_ni),
    .grant_i  (wr_tok_i),
    .release_i(wr_pass_o),
    .own_o    (wr_tok_q)
  );

  dsx_token u_rd_tok (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_i  (~first_load_ni),
    .grant_i  (rd_tok_i),
    .release_i(rd_pass_o),
    .own_o    (rd_tok_q)
  );

  dsx_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (wr_acc),
    .ptr_o (wr_ptr),
    .last_o(wr_last)
  );

  dsx_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (rd_acc),
    .ptr_o (rd_ptr),
    .last_o(rd_last)
  );

  dsx_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (wr_acc),
    .dec_i  (rd_acc),
    .empty_o(empty_o),
    .full_o (full_o)
  );

  dsx_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_acc),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .re_i    (rd_acc),
    .raddr_i (rd_ptr),
    .rdata_o (rd_data_o),
    .rvalid_o(rd_valid_o)
  );
endmodule

// File: rtl/depth_slice_chk.sv
module depth_slice_chk #(
  parameter int DW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          chain_en_i,
  input logic          first_load_ni,
  input logic          wr_en_i,
  input logic [DW-1:0] wr_data_i,
  input logic          rd_en_i,
  input logic          wr_tok_i,
  input logic          rd_tok_i,
  input logic [DW-1:0] rd_data_o,
  input logic          rd_valid_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          wr_pass_o,
  input logic          rd_pass_o,
  input logic          wr_own_o,
  input logic          rd_own_o
);
  // R4
  wr_pass_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pass_o |-> (wr_en_i && wr_own_o && !full_o));

  // R4
  wr_pass_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pass_o && !wr_tok_i) |=> !wr_own_o);

  // R5
  rd_pass_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pass_o |-> (rd_en_i && rd_own_o && !empty_o));

  // R5
  rd_pass_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pass_o && !rd_tok_i) |=> !rd_own_o);

  // R6
  wr_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_en_i && wr_tok_i) |=> wr_own_o);

  // R6
  rd_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_en_i && rd_tok_i) |=> rd_own_o);

  // R8
  solo_no_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_en_i |-> (!wr_pass_o && !rd_pass_o && wr_own_o && rd_own_o));

  // R3
  rd_valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_en_i && rd_own_o && !empty_o));

  // R3
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0));

  // R9
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R7
  no_wr_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_en_i && !wr_own_o && !rd_own_o) |=> $stable(empty_o) && $stable(full_o));
endmodule

bind depth_slice depth_slice_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_depth_slice.sv
module tb_depth_slice;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 9;
  localparam int D  = 4;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic          chain = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;

  logic [NS-1:0] wpass, rpass, wown, rown, emp, ful, vld;
  logic [DW-1:0] rdat [NS];

  depth_slice #(.DW(DW), .DEPTH(D)) dut (
    .clk_i(clk), .rst_ni(rst_n), .chain_en_i(chain), .first_load_ni(1'b0),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .wr_tok_i(wpass[2]), .rd_tok_i(rpass[2]),
    .rd_data_o(rdat[0]), .rd_valid_o(vld[0]), .empty_o(emp[0]), .full_o(ful[0]),
    .wr_pass_o(wpass[0]), .rd_pass_o(rpass[0]), .wr_own_o(wown[0]), .rd_own_o(rown[0]));

  depth_slice #(.DW(DW), .DEPTH(D)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .chain_en_i(chain), .first_load_ni(1'b1),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .wr_tok_i(wpass[0]), .rd_tok_i(rpass[0]),
    .rd_data_o(rdat[1]), .rd_valid_o(vld[1]), .empty_o(emp[1]), .full_o(ful[1]),
    .wr_pass_o(wpass[1]), .rd_pass_o(rpass[1]), .wr_own_o(wown[1]), .rd_own_o(rown[1]));

  depth_slice #(.DW(DW), .DEPTH(D)) dut_c (
    .clk_i(clk), .rst_ni(rst_n), .chain_en_i(chain), .first_load_ni(1'b1),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .wr_tok_i(wpass[1]), .rd_tok_i(rpass[1]),
    .rd_data_o(rdat[2]), .rd_valid_o(vld[2]), .empty_o(emp[2]), .full_o(ful[2]),
    .wr_pass_o(wpass[2]), .rd_pass_o(rpass[2]), .wr_own_o(wown[2]), .rd_own_o(rown[2]));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int q[$];
  int wcnt, rcnt;
  int scnt [NS];
  bit exp_vld;
  int exp_dat;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int slice_of(int n);
    return (n / D) % NS;
  endfunction

  function automatic int loc_of(int n);
    return n % D;
  endfunction

  task automatic model_clear();
    q.delete();
    wcnt = 0; rcnt = 0; exp_vld = 0; exp_dat = 0;
    for (int s = 0; s < NS; s++) scnt[s] = 0;
  endtask

  task automatic do_reset(bit ring);
    @(posedge clk); #1;
    rst_n = 1'b0; chain = ring; wr_en = 0; rd_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state of every slice
    for (int s = 0; s < NS; s++) begin
      chk("R1 empty", emp[s], 1);
      chk("R1 full", ful[s], 0);
      chk("R1 valid", vld[s], 0);
      chk("R1 data", rdat[s], 0);
      chk("R1 wpass", wpass[s], 0);
      if (ring) begin
        chk("R1 wown", wown[s], s == 0);
        chk("R1 rown", rown[s], s == 0);
      end
    end
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic step(bit we, bit re, int data);
    int  cap;
    bit  aw, ar;
    int  ws, wl, rs, rl;
    @(posedge clk); #1;
    wr_en = we; rd_en = re; wdata = DW'(data);
    @(negedge clk);
    cap = chain ? NS * D : D;
    aw = we && (q.size() < cap);
    ar = re && (q.size() > 0);
    ws = slice_of(wcnt); wl = loc_of(wcnt);
    rs = slice_of(rcnt); rl = loc_of(rcnt);
    if (chain) begin
      chk("R3 ring valid", |vld, exp_vld);
      chk("R3 ring data", vld[0] ? rdat[0] : vld[1] ? rdat[1] : rdat[2], exp_dat);
      chk("R3 ring one-hot valid", $countones(vld) <= 1, 1);
      // R9 composite flags
      chk("R9 composite empty", &emp, q.size() == 0);
      chk("R9 composite full", &ful, q.size() == cap);
      for (int s = 0; s < NS; s++) begin
        chk("R6 wown", wown[s], s == ws);
        chk("R6 rown", rown[s], s == rs);
        chk("R4 wpass", wpass[s], aw && s == ws && wl == D-1);
        chk("R5 rpass", rpass[s], ar && s == rs && rl == D-1);
        // R7 non-holders keep their flags
        chk("R7 slice empty", emp[s], scnt[s] == 0);
        chk("R9 slice full", ful[s], scnt[s] == D);
      end
    end else begin
      chk("R8 valid", vld[0], exp_vld);
      chk("R8 data", rdat[0], exp_dat);
      chk("R8 empty", emp[0], q.size() == 0);
      chk("R8 full", ful[0], q.size() == D);
      chk("R8 wpass", wpass[0], 0);
      chk("R8 rpass", rpass[0], 0);
      chk("R8 owns", {wown[0], rown[0]}, 3);
    end
    if (ar) begin
      exp_dat = q.pop_front(); exp_vld = 1;
      scnt[rs]--; rcnt++;
    end else begin
      exp_dat = 0; exp_vld = 0;
    end
    if (aw) begin
      q.push_back(data);
      scnt[ws]++; wcnt++;
    end
  endtask

  task automatic burst(int cycles, int wpct, int rpct);
    for (int i = 0; i < cycles; i++)
      step(($urandom % 100) < wpct, ($urandom % 100) < rpct, $urandom % (1 << DW));
  endtask

  initial begin
    void'($urandom(32'h5A17));
    // Stand-alone phase: R8, R2, R3, R10
    do_reset(1'b0);
    for (int i = 0; i < D + 3; i++) step(1, 0, 100 + i);   // fill and overrun (R2)
    step(1, 1, 7);                                          // R10 at full
    for (int i = 0; i < D + 3; i++) step(0, 1, 0);          // drain and underrun
    burst(300, 60, 50);
    // Ring phase
    do_reset(1'b1);
    for (int i = 0; i < NS * D + 4; i++) step(1, 0, i + 1); // R4 walk to composite full
    step(1, 1, 55);                                         // R10 at composite full
    for (int i = 0; i < NS * D + 4; i++) step(0, 1, 0);     // R5 drain past empty
    for (int i = 0; i < 3 * NS * D; i++) step(1, 1, 200 + i); // R10 streaming across slices
    burst(2000, 80, 30);
    burst(2000, 30, 80);
    burst(3000, 55, 55);
    for (int i = 0; i < NS * D + 2; i++) step(0, 1, 0);
    step(0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule